// File: doc/BRIEF.md
# Distributed-Arithmetic Sum-of-Products Unit

This block computes the dot product of K input samples with K constant coefficients without using any multiplier. The taps are split into groups of GRP. Each group has a small lookup table whose entry j holds the sum of the group's coefficients selected by the set bits of j. For every bit position of the samples, the bits at that position across the group's samples form a table address. The looked-up partial sums are shifted by their bit position and added together. All bit positions are handled in parallel, with one table copy per bit, so a new sample set can be accepted on every enabled clock.

A registered shift-add tree merges the bit-position terms inside each group. A second registered tree then adds the group results. Coefficients are fixed at elaboration through a packed parameter. A format parameter selects two's-complement or unsigned samples. In two's-complement mode the term for the most significant bit position carries a negative weight. A clock enable stalls the whole pipeline, which lets the block run at a reduced sample rate.

Top module: `da_sop`

## Requirements
- R1: While `rst` is high at a rising edge, every pipeline register clears, so `y_out` reads 0 at the following edge and stays 0 until enabled data has flowed through.
- R2: With FMT = FMT_TWOS, `y_out` read as a signed OUT_W-bit number equals the sum over t of c[t]·x[t]. Here x[t] is `x_in[t*DW +: DW]` and c[t] is `COEFS[t*CW +: CW]`, both read as two's complement.
- R3: The result for the samples captured at an enabled edge appears on `y_out` after exactly LAT = 1 + clog2(DW) + clog2(ceil(K/GRP)) enabled edges, counting the capturing edge; with the defaults LAT = 5. A new sample set is accepted on every enabled edge.
- R4: At an edge where `en` is low, no register changes: `y_out` holds its value and the value of `x_in` at that edge has no effect on any later result.
- R5: In two's-complement mode the most significant bit position is weighted by −2^(DW−1), so the most negative sample value (0x80 for DW = 8) on every tap yields −128·Σc[t].
- R6: With FMT = FMT_UNSIGNED, each x[t] is read as an unsigned number from 0 to 2^DW − 1, and `y_out` (signed) equals the sum of x[t]·c[t].
- R7: When K is not a multiple of GRP, the missing taps of the last group behave as zero coefficients with zero samples, and the result is still the exact K-tap sum.
- R8: After LAT consecutive enabled edges with `x_in` = 0, `y_out` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Clock enable; the pipeline advances only when high |
| x_in | input | K*DW | K samples, tap t in bits [t*DW +: DW] |
| y_out | output | OUT_W | Signed sum of products, OUT_W = DW + CW + clog2(K) + 1 |

## Verification
The assertions assume that `en` and `rst` are only sampled at rising edges and that nothing downstream expects an answer before LAT enabled edges. The bench drives every input at the falling edge and keeps `rst` high from time zero, so each check starts from cleared registers. The vectors include all-maximum and all-minimum samples, single-tap impulses and alternating signs, which stay within the output width that R2 sizes. The bench also opens a gap in `en` while it drives a different sample set on `x_in`, and confirms that this set never reaches `y_out`.

// File: rtl/da_sop_pkg.sv
package da_sop_pkg;

    typedef enum logic {
        FMT_UNSIGNED = 1'b0,
        FMT_TWOS     = 1'b1
    } sample_fmt_e;

    // Output width large enough for the exact K-tap sum in either format
    function automatic int sop_out_w(int dw, int cw, int k);
        return dw + cw + $clog2(k) + 1;
    endfunction

    // Width of one table entry: sum of g signed cw-bit coefficients
    function automatic int tbl_w(int cw, int g);
        return cw + $clog2(g);
    endfunction

    function automatic int group_count(int k, int g);
        return (k + g - 1) / g;
    endfunction

    // Table register, bit-merge tree, group-merge tree
    function automatic int pipe_latency(int dw, int k, int g);
        return 1 + $clog2(dw) + $clog2(group_count(k, g));
    endfunction

endpackage

// File: rtl/da_lut.sv
module da_lut #(
    parameter int G  = 4,
    parameter int CW = 8,
    parameter int TW = 10,
    parameter logic [G*CW-1:0] COEFS = '0
) (
    input  logic [G-1:0]          addr,
    output logic signed [TW-1:0]  data
);
    localparam int DEPTH = 1 << G;

    // Entry j: sum of coefficients whose index bit is set in j
    function automatic logic signed [TW-1:0] entry(int j);
        logic signed [TW-1:0] acc;
        acc = '0;
        for (int t = 0; t < G; t++) begin
            if (((j >> t) & 1) == 1)
                acc = acc + TW'($signed(COEFS[t*CW +: CW]));
        end
        return acc;
    endfunction

    logic signed [TW-1:0] rom [DEPTH];

    for (genvar j = 0; j < DEPTH; j++) begin : g_ent
        assign rom[j] = entry(j);
    end

    assign data = rom[addr];

endmodule

// File: rtl/da_add_tree.sv
module da_add_tree #(
    parameter int N = 8,
    parameter int W = 20
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [N*W-1:0]   in_flat,
    output logic [W-1:0]     sum
);
    localparam int LV = $clog2(N);
    localparam int P  = 1 << LV;

    logic [P*W-1:0] padded;

    always_comb begin
        padded = '0;
        padded[N*W-1:0] = in_flat;
    end

    for (genvar lv = 0; lv <= LV; lv++) begin : g_lv
        localparam int CNT = P >> lv;
        logic signed [W-1:0] v [CNT];
        if (lv == 0) begin : g_in
            always_comb begin
                for (int i = 0; i < CNT; i++)
                    v[i] = padded[i*W +: W];
            end
        end else begin : g_add
            always_ff @(posedge clk) begin
                if (rst) begin
                    for (int i = 0; i < CNT; i++) v[i] <= '0;
                end else if (en) begin
                    for (int i = 0; i < CNT; i++)
                        v[i] <= g_lv[lv-1].v[2*i] + g_lv[lv-1].v[2*i+1];
                end
            end
        end
    end

    assign sum = g_lv[LV].v[0];

    if (LV > 0) begin : g_fill
        localparam int FW = $clog2(LV + 1);
        logic [FW-1:0] fill_cnt;
        always_ff @(posedge clk) begin
            if (rst)
                fill_cnt <= '0;
            else if (en && (int'(fill_cnt) < LV))
                fill_cnt <= fill_cnt + 1'b1;
        end
        // R3
        tree_fill_chk: assert property (@(posedge clk) disable iff (rst)
            (int'(fill_cnt) < LV) |-> (sum == '0));
    end

endmodule

// File: rtl/da_group.sv
module da_group
    import da_sop_pkg::*;
#(
    parameter int          G   = 4,
    parameter int          DW  = 8,
    parameter int          CW  = 8,
    parameter int          OW  = 20,
    parameter sample_fmt_e FMT = FMT_TWOS,
    parameter logic [G*CW-1:0] COEFS = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [G*DW-1:0]   x_flat,
    output logic [OW-1:0]     sum
);
    localparam int TW = tbl_w(CW, G);

    logic [DW*OW-1:0] terms_flat;

    for (genvar b = 0; b < DW; b++) begin : g_bit
        logic [G-1:0]          slice;
        logic signed [TW-1:0]  part;
        logic signed [OW-1:0]  wt;
        logic signed [OW-1:0]  term_q;

        for (genvar t = 0; t < G; t++) begin : g_tap
            assign slice[t] = x_flat[t*DW + b];
        end

        da_lut #(.G(G), .CW(CW), .TW(TW), .COEFS(COEFS)) u_lut (
            .addr (slice),
            .data (part)
        );

        if (FMT == FMT_TWOS && b == DW - 1) begin : g_neg
            assign wt = -(OW'(part) <<< b);
        end else begin : g_pos
            assign wt = OW'(part) <<< b;
        end

        always_ff @(posedge clk) begin
            if (rst)
                term_q <= '0;
            else if (en)
                term_q <= wt;
        end

        assign terms_flat[b*OW +: OW] = term_q;
    end

    da_add_tree #(.N(DW), .W(OW)) u_bits (
        .clk     (clk),
        .rst     (rst),
        .en      (en),
        .in_flat (terms_flat),
        .sum     (sum)
    );

endmodule

// File: rtl/da_sop.sv
module da_sop
    import da_sop_pkg::*;
#(
    parameter int          K   = 8,
    parameter int          DW  = 8,
    parameter int          CW  = 8,
    parameter int          GRP = 4,
    parameter sample_fmt_e FMT = FMT_TWOS,
    parameter logic [K*CW-1:0] COEFS = 64'h40FF_7F80_2D13_F903,
    localparam int         OUT_W = sop_out_w(DW, CW, K)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               en,
    input  logic [K*DW-1:0]    x_in,
    output logic [OUT_W-1:0]   y_out
);
    localparam int NG   = group_count(K, GRP);
    localparam int PADK = NG * GRP;
    localparam int LAT  = pipe_latency(DW, K, GRP);
    localparam logic [PADK*CW-1:0] COEF_PAD = (PADK*CW)'(COEFS);

    logic [PADK*DW-1:0]  x_pad;
    logic [NG*OUT_W-1:0] grp_flat;

    assign x_pad = (PADK*DW)'(x_in);

    for (genvar g = 0; g < NG; g++) begin : g_grp
        da_group #(
            .G     (GRP),
            .DW    (DW),
            .CW    (CW),
            .OW    (OUT_W),
            .FMT   (FMT),
            .COEFS (COEF_PAD[g*GRP*CW +: GRP*CW])
        ) u_grp (
            .clk    (clk),
            .rst    (rst),
            .en     (en),
            .x_flat (x_pad[g*GRP*DW +: GRP*DW]),
            .sum    (grp_flat[g*OUT_W +: OUT_W])
        );
    end

    da_add_tree #(.N(NG), .W(OUT_W)) u_groups (
        .clk     (clk),
        .rst     (rst),
        .en      (en),
        .in_flat (grp_flat),
        .sum     (y_out)
    );

    // Count of consecutive enabled edges with all-zero samples, saturating
    localparam int ZW = $clog2(LAT + 1);
    logic [ZW-1:0] zero_run;

    always_ff @(posedge clk) begin
        if (rst)
            zero_run <= '0;
        else if (en) begin
            if (x_in != '0)
                zero_run <= '0;
            else if (int'(zero_run) < LAT)
                zero_run <= zero_run + 1'b1;
        end
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (y_out == '0));

    // R4
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(y_out));

    // R8
    zero_flush_chk: assert property (@(posedge clk) disable iff (rst)
        (int'(zero_run) == LAT) |-> (y_out == '0));

endmodule

// File: tb/da_sop_tb_top.sv
module da_sop_tb_top;
    import da_sop_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int OW  = 20;
    localparam int LAT = 5;   // 1 + clog2(8) + clog2(2) for both instances
    localparam int NV  = 8;

    localparam logic [63:0] VEC_S [NV] = '{
        64'h0000_0000_0000_0000,
        64'h7F7F_7F7F_7F7F_7F7F,
        64'h8080_8080_8080_8080,
        64'h0000_0000_0000_0001,
        64'hFF00_0000_0000_0000,
        64'h01FF_01FF_01FF_01FF,
        64'h1234_5678_9ABC_DEF0,
        64'h8000_0000_0000_007F
    };
    localparam logic [47:0] VEC_U [NV] = '{
        48'h0000_0000_0000,
        48'hFFFF_FFFF_FFFF,
        48'h0000_0000_0080,
        48'h0102_0304_05FF,
        48'hA5A5_A5A5_A5A5,
        48'h00FF_00FF_00FF,
        48'h7F80_0000_0001,
        48'h1234_5678_9ABC
    };

    localparam int CS [8] = '{3, -7, 19, 45, -128, 127, -1, 64};
    localparam int CU [6] = '{9, 127, 34, -16, 5, -127};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en  = 1'b0;
    logic [63:0]   xs = '0;
    logic [47:0]   xu = '0;
    logic [OW-1:0] ys;
    logic [OW-1:0] yu;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    da_sop #(
        .K(8), .DW(8), .CW(8), .GRP(4), .FMT(FMT_TWOS),
        .COEFS(64'h40FF_7F80_2D13_F903)
    ) dut_i (
        .clk(clk), .rst(rst), .en(en), .x_in(xs), .y_out(ys)
    );

    da_sop #(
        .K(6), .DW(8), .CW(8), .GRP(4), .FMT(FMT_UNSIGNED),
        .COEFS(48'h8105_F022_7F09)
    ) dut_u_i (
        .clk(clk), .rst(rst), .en(en), .x_in(xu), .y_out(yu)
    );

    function automatic longint exp_s(logic [63:0] v);
        longint acc = 0;
        for (int t = 0; t < 8; t++)
            acc += longint'($signed(v[t*8 +: 8])) * longint'(CS[t]);
        return acc;
    endfunction

    function automatic longint exp_u(logic [47:0] v);
        longint acc = 0;
        for (int t = 0; t < 6; t++)
            acc += longint'(v[t*8 +: 8]) * longint'(CU[t]);
        return acc;
    endfunction

    function automatic longint sval(logic [OW-1:0] y);
        return longint'($signed(y));
    endfunction

    task automatic check(string req, longint act, longint expv);
        checks++;
        if (act != expv) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        longint held_s;
        longint held_u;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check("R1 reset signed", sval(ys), 0);
        check("R1 reset unsigned", sval(yu), 0);

        // Streaming table walk: one new vector per enabled edge
        for (int n = 0; n < NV + LAT; n++) begin
            @(negedge clk);
            if (n >= LAT) begin
                check((n - LAT == 2) ? "R5 min samples" : "R2 signed sum",
                      sval(ys), exp_s(VEC_S[n-LAT]));
                check("R6 unsigned, R7 partial group",
                      sval(yu), exp_u(VEC_U[n-LAT]));
            end
            en = 1'b1;
            xs = (n < NV) ? VEC_S[n] : '0;
            xu = (n < NV) ? VEC_U[n] : '0;
        end

        // Zero flush, then enable gap with foreign samples
        @(negedge clk);
        check("R8 zero flush signed", sval(ys), 0);
        check("R8 zero flush unsigned", sval(yu), 0);
        xs = VEC_S[6];
        xu = VEC_U[6];
        @(negedge clk);
        en = 1'b0;
        xs = VEC_S[1];
        xu = VEC_U[1];
        held_s = sval(ys);
        held_u = sval(yu);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check("R4 hold signed", sval(ys), held_s);
            check("R4 hold unsigned", sval(yu), held_u);
        end
        en = 1'b1;
        xs = '0;
        xu = '0;
        for (int k = 2; k <= LAT; k++) begin
            @(negedge clk);
            if (k == LAT - 1) begin
                check("R3 not early signed", sval(ys), 0);
                check("R3 not early unsigned", sval(yu), 0);
            end
            if (k == LAT) begin
                check("R3 latency signed", sval(ys), exp_s(VEC_S[6]));
                check("R4 gap samples ignored", sval(yu), exp_u(VEC_U[6]));
            end
        end

        // Reset in the middle of a busy pipeline
        xs = VEC_S[5];
        xu = VEC_U[5];
        repeat (LAT + 1) @(negedge clk);
        check("R2 before mid reset", sval(ys), exp_s(VEC_S[5]));
        rst = 1'b1;
        @(negedge clk);
        check("R1 mid reset signed", sval(ys), 0);
        check("R1 mid reset unsigned", sval(yu), 0);
        rst = 1'b0;
        en = 1'b0;
        xs = '0;
        xu = '0;
        @(negedge clk);

        summary();
        $finish;
    end

endmodule